// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration image into a programmable device over a passive serial link with active-low control lines. On a start pulse it holds the device's configuration request line low for a timed interval, confirms that the device has pulled its status line low by the end of that interval, releases the request, lets the line settle and then waits, with a timeout, for the device to let go of its status line. After that handshake it accepts image bytes on a valid/ready stream and shifts each one out on a data line under a generated data clock, least significant bit first.

Once the byte marked as last has been shifted out, the loader looks once at the device's configuration-complete input. If that input is high, a fixed burst of extra clock pulses follows for device start-up and the run ends as a success. Otherwise the run ends as a failure. The result and a failure code stay on the outputs until the next start. All waits are counts of system clock cycles set by parameters.

Top module: `ps_serial_loader`

## Requirements
- R1: A start pulse seen while the state output reads idle (0), ok (2) or fail (3) drives `cfg_n_o` low for exactly PULSE_CYC clock cycles, after which it returns high.
- R2: If `status_n_i` is still high in the last cycle of the low pulse, the run ends with state fail (3) and error code 1. No data clock pulse is produced.
- R3: After `cfg_n_o` returns high, `status_n_i` is ignored for SETTLE_CYC cycles. It is then sampled on each of the next REL_TO_CYC clock edges, and a high value on any of them, the last one included, starts streaming. If it stays low on all of them, the run ends with state fail and error code 2.
- R4: Bytes are taken only while streaming and only when the previous byte has been fully shifted out. Each byte gives exactly 8 rising edges of `dclk_o`, with bit 0 on `data_o` at the first rising edge and bit 7 at the last.
- R5: Each bit has a low phase of `dclk_o` of at least HALF_CYC cycles, during which the bit is placed on `data_o`, followed by a high phase of exactly HALF_CYC cycles. `data_o` never changes while `dclk_o` is high.
- R6: After the byte that carries `s_last_i` has been shifted out, `conf_done_i` is sampled once. If it is low, the run ends with state fail and error code 3, and no further clock pulses follow.
- R7: If `conf_done_i` is high at that point, exactly TAIL_CLKS more rising edges of `dclk_o` follow. The clock then rests low and the run ends with state ok (2) and error code 0.
- R8: The state output encodes idle as 0, busy as 1, ok as 2 and fail as 3. The error code is cleared to 0 when a run starts and keeps its value until the next start.
- R9: A start pulse during a busy run has no effect: `cfg_n_o` stays high and the run finishes as if no pulse had been given.
- R10: While reset is held (synchronous, active low), and until the first start after it, `cfg_n_o` is high, `dclk_o` and `s_ready_o` are low, the state reads idle and the error code reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a load |
| s_data_i | input | DATA_W | Image byte |
| s_valid_i | input | 1 | Image byte is present |
| s_last_i | input | 1 | Present byte is the final one |
| s_ready_o | output | 1 | Loader takes the byte on this edge |
| cfg_n_o | output | 1 | Configuration request to the device, active low |
| dclk_o | output | 1 | Data clock to the device |
| data_o | output | 1 | Serial data to the device |
| status_n_i | input | 1 | Device status line, active low |
| conf_done_i | input | 1 | Device reports configuration complete |
| state_o | output | 2 | 0 idle, 1 busy, 2 ok, 3 fail |
| err_o | output | 2 | 0 none, 1 status never asserted, 2 status release timeout, 3 completion flag low |

## Verification
A wrong handshake state is visible at `cfg_n_o` within one cycle, as a pulse that is too short or too long, or as a request that is raised again during a run. A wrong state also shows at `state_o`/`err_o` on the cycle the timeout window closes, so the bench sets the status release exactly on the last sampled edge and on the first edge after it. A fault in the serializer shows on the device side within one bit time: a bit in the wrong order, a missing or extra rising edge, or a data change while the clock is high. The bench counts every rising edge and rebuilds each received byte from them. A completion check that is skipped or inverted shows as the wrong number of trailing edges and the wrong final code.

// File: rtl/ps_loader_pkg.sv
// Package: shared encodings for the passive serial loader.
// Assumes: consumers import it; values of the status and error codes are
// visible at the top-level ports and must not be renumbered.
package ps_loader_pkg;

    // Externally visible run state.
    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_BUSY = 2'd1,
        RUN_OK   = 2'd2,
        RUN_FAIL = 2'd3
    } run_state_e;

    // Externally visible failure reason.
    typedef enum logic [1:0] {
        FAULT_NONE      = 2'd0,
        FAULT_NO_ASSERT = 2'd1,
        FAULT_REL_TMO   = 2'd2,
        FAULT_DONE_LOW  = 2'd3
    } fault_e;

    // Internal sequencer phases.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PULSE,
        PH_SETTLE,
        PH_WAITREL,
        PH_STREAM,
        PH_CHECK,
        PH_TAIL,
        PH_OK,
        PH_FAIL
    } phase_e;

endpackage

// File: rtl/ps_loader_timer.sv
// Module: down-counting interval timer for the handshake windows.
// Loading N makes expired_o read high on the (N+1)-th edge after the load.
// Assumes: the caller reloads before each window; expired_o is meaningless
// outside a window.
module ps_loader_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count down from the loaded value and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Window has run out.
    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ps_loader_serializer.sv
// Module: bit serializer producing the data clock and data line.
// Shifts a word out least significant bit first, or produces a burst of
// clock pulses with the data line held, one bit per low/high clock period.
// Assumes: load_i is raised only while busy_o is low; nbits_i is nonzero.
module ps_loader_serializer #(
    parameter int DATA_W   = 8,
    parameter int HALF_CYC = 4,
    parameter int MAX_N    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              use_data_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic [$clog2(MAX_N+1)-1:0] nbits_i,
    output logic              dclk_o,
    output logic              data_o,
    output logic              busy_o
);

    localparam int N_W = $clog2(MAX_N + 1);
    localparam int H_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [H_W-1:0] HALF_M1 = H_W'(HALF_CYC - 1);

    logic [DATA_W-1:0] shreg_q;
    logic [N_W-1:0]    left_q;
    logic [H_W-1:0]    hcnt_q;
    logic              high_q;
    logic              with_data_q;
    logic              dclk_q;
    logic              data_q;

    // Phase sequencing: low half (data placed), high half, then next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            left_q      <= '0;
            hcnt_q      <= '0;
            high_q      <= 1'b0;
            with_data_q <= 1'b0;
            dclk_q      <= 1'b0;
            data_q      <= 1'b0;
        end else if (load_i && (left_q == '0)) begin
            shreg_q     <= din_i;
            left_q      <= nbits_i;
            hcnt_q      <= HALF_M1;
            high_q      <= 1'b0;
            with_data_q <= use_data_i;
            dclk_q      <= 1'b0;
            if (use_data_i) begin
                data_q <= din_i[0];
            end
        end else if (left_q != '0) begin
            if (hcnt_q != '0) begin
                hcnt_q <= hcnt_q - 1'b1;
            end else if (!high_q) begin
                dclk_q <= 1'b1;
                high_q <= 1'b1;
                hcnt_q <= HALF_M1;
            end else begin
                dclk_q  <= 1'b0;
                high_q  <= 1'b0;
                hcnt_q  <= HALF_M1;
                left_q  <= left_q - 1'b1;
                shreg_q <= shreg_q >> 1;
                if (with_data_q && (left_q != N_W'(1))) begin
                    data_q <= shreg_q[1];
                end
            end
        end
    end

    // Outputs straight from registers.
    assign dclk_o = dclk_q;
    assign data_o = data_q;
    assign busy_o = (left_q != '0);

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) dclk_q |-> $stable(data_q)); // R5
    AST_CLK_RESTS_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !dclk_q); // R7
    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) load_i |-> !busy_o); // R4

endmodule

// File: rtl/ps_serial_loader.sv
// Module: passive serial configuration loader (top).
// Runs the request/status handshake with timed windows, streams bytes LSB
// first, checks the completion flag once and sends trailing clocks.
// Assumes: status_n_i and conf_done_i are already synchronous to clk;
// PULSE_CYC, SETTLE_CYC and REL_TO_CYC are all at least 1.
module ps_serial_loader #(
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 500,
    parameter int SETTLE_CYC = 500,
    parameter int REL_TO_CYC = 20000,
    parameter int HALF_CYC   = 4,
    parameter int TAIL_CLKS  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_valid_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    output logic              cfg_n_o,
    output logic              dclk_o,
    output logic              data_o,
    input  logic              status_n_i,
    input  logic              conf_done_i,
    output logic [1:0]        state_o,
    output logic [1:0]        err_o
);

    import ps_loader_pkg::*;

    localparam int MAX_A   = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int MAX_T   = (MAX_A > REL_TO_CYC) ? MAX_A : REL_TO_CYC;
    localparam int CNT_W   = $clog2(MAX_T + 1);
    localparam int SER_MAX = (TAIL_CLKS > DATA_W) ? TAIL_CLKS : DATA_W;
    localparam int N_W     = $clog2(SER_MAX + 1);

    phase_e            phase_q;
    fault_e            fault_q;
    logic              cfg_n_q;
    logic              last_seen_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;

    logic              ser_load;
    logic              ser_use_data;
    logic [DATA_W-1:0] ser_din;
    logic [N_W-1:0]    ser_nbits;
    logic              ser_busy;
    logic              ser_dclk;
    logic              ser_data;
    logic              take_byte;

    ps_loader_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    ps_loader_serializer #(
        .DATA_W   (DATA_W),
        .HALF_CYC (HALF_CYC),
        .MAX_N    (SER_MAX)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ser_load),
        .use_data_i (ser_use_data),
        .din_i      (ser_din),
        .nbits_i    (ser_nbits),
        .dclk_o     (ser_dclk),
        .data_o     (ser_data),
        .busy_o     (ser_busy)
    );

    // Byte handshake: open only while streaming with the serializer free.
    assign s_ready_o = (phase_q == PH_STREAM) && !ser_busy && !last_seen_q;
    assign take_byte = s_valid_i && s_ready_o;

    // Timer reloads and serializer launches for the current phase.
    always_comb begin
        tmr_load     = 1'b0;
        tmr_val      = '0;
        ser_load     = 1'b0;
        ser_use_data = 1'b1;
        ser_din      = s_data_i;
        ser_nbits    = N_W'(DATA_W);
        case (phase_q)
            PH_IDLE, PH_OK, PH_FAIL: begin
                if (start_i) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(PULSE_CYC - 1);
                end
            end
            PH_PULSE: begin
                if (tmr_exp && !status_n_i) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETTLE_CYC - 1);
                end
            end
            PH_SETTLE: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REL_TO_CYC - 1);
                end
            end
            PH_STREAM: begin
                ser_load = take_byte;
            end
            PH_CHECK: begin
                if (conf_done_i) begin
                    ser_load     = 1'b1;
                    ser_use_data = 1'b0;
                    ser_din      = '0;
                    ser_nbits    = N_W'(TAIL_CLKS);
                end
            end
            default: begin
            end
        endcase
    end

    // Phase sequencing, request line and failure code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            fault_q     <= FAULT_NONE;
            cfg_n_q     <= 1'b1;
            last_seen_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE, PH_OK, PH_FAIL: begin
                    if (start_i) begin
                        phase_q     <= PH_PULSE;
                        fault_q     <= FAULT_NONE;
                        cfg_n_q     <= 1'b0;
                        last_seen_q <= 1'b0;
                    end
                end
                PH_PULSE: begin
                    if (tmr_exp) begin
                        cfg_n_q <= 1'b1;
                        if (status_n_i) begin
                            phase_q <= PH_FAIL;
                            fault_q <= FAULT_NO_ASSERT;
                        end else begin
                            phase_q <= PH_SETTLE;
                        end
                    end
                end
                PH_SETTLE: begin
                    if (tmr_exp) begin
                        phase_q <= PH_WAITREL;
                    end
                end
                PH_WAITREL: begin
                    if (status_n_i) begin
                        phase_q <= PH_STREAM;
                    end else if (tmr_exp) begin
                        phase_q <= PH_FAIL;
                        fault_q <= FAULT_REL_TMO;
                    end
                end
                PH_STREAM: begin
                    if (take_byte && s_last_i) begin
                        last_seen_q <= 1'b1;
                    end
                    if (last_seen_q && !ser_busy) begin
                        phase_q <= PH_CHECK;
                    end
                end
                PH_CHECK: begin
                    if (conf_done_i) begin
                        phase_q <= PH_TAIL;
                    end else begin
                        phase_q <= PH_FAIL;
                        fault_q <= FAULT_DONE_LOW;
                    end
                end
                PH_TAIL: begin
                    if (!ser_busy) begin
                        phase_q <= PH_OK;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    // External state code from the internal phase.
    always_comb begin
        case (phase_q)
            PH_IDLE: state_o = RUN_IDLE;
            PH_OK:   state_o = RUN_OK;
            PH_FAIL: state_o = RUN_FAIL;
            default: state_o = RUN_BUSY;
        endcase
    end

    assign err_o   = fault_q;
    assign cfg_n_o = cfg_n_q;
    assign dclk_o  = ser_dclk;
    assign data_o  = ser_data;

    AST_NO_CLK_IN_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_PULSE || phase_q == PH_SETTLE || phase_q == PH_WAITREL) |-> !ser_dclk); // R2
    AST_REQ_HIGH_OUTSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (phase_q != PH_PULSE) |-> cfg_n_q); // R1
    AST_FAIL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n) (state_o == RUN_FAIL) |-> (err_o != FAULT_NONE)); // R8
    AST_OK_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n) (state_o == RUN_OK) |-> (err_o == FAULT_NONE)); // R7
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start_i && (phase_q == PH_STREAM || phase_q == PH_TAIL || phase_q == PH_SETTLE)) |=> cfg_n_q); // R9

endmodule

// File: tb/ps_serial_loader_tb.sv
`timescale 1ns/1ps
module ps_serial_loader_tb;

    localparam int DW     = 8;
    localparam int PULSE  = 10;
    localparam int SETTLE = 6;
    localparam int REL_TO = 40;
    localparam int HALF   = 2;
    localparam int TAIL   = 12;
    // R3: the device model releases its line after edge (1+delay) counted from
    // the first edge that sees cfg_n high; the DUT sees it one edge later.
    // The last accepted sampling edge is SETTLE+REL_TO after cfg_n rises.
    localparam int DLY_LAST = SETTLE + REL_TO - 2;

    typedef struct packed {
        logic [1:0] mode;     // 0 normal, 1 never asserts, 2 never releases
        logic [7:0] delay;
        logic       cdone;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [1:0] exp_st;
        logic [1:0] exp_err;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd3,            1'b1, 8'hA5, 8'h3C, 2'd2, 2'd0},
        '{2'd0, 8'd0,            1'b1, 8'h01, 8'h80, 2'd2, 2'd0},
        '{2'd1, 8'd0,            1'b1, 8'h55, 8'hAA, 2'd3, 2'd1},
        '{2'd2, 8'd0,            1'b1, 8'h12, 8'h34, 2'd3, 2'd2},
        '{2'd0, 8'd5,            1'b0, 8'hFF, 8'h00, 2'd3, 2'd3},
        '{2'd0, 8'(DLY_LAST),    1'b1, 8'hC3, 8'h7E, 2'd2, 2'd0},
        '{2'd0, 8'(DLY_LAST+1),  1'b1, 8'h99, 8'h66, 2'd3, 2'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic s_valid = 1'b0;
    logic s_last = 1'b0;
    logic s_ready;
    logic cfg_n, dclk, sdata;
    logic status_n;
    logic conf_done = 1'b0;
    logic [1:0] st, err;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ps_serial_loader #(
        .DATA_W(DW), .PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE),
        .REL_TO_CYC(REL_TO), .HALF_CYC(HALF), .TAIL_CLKS(TAIL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last),
        .s_ready_o(s_ready), .cfg_n_o(cfg_n), .dclk_o(dclk), .data_o(sdata),
        .status_n_i(status_n), .conf_done_i(conf_done),
        .state_o(st), .err_o(err)
    );

    // Device model for the status line.
    logic [1:0] dev_mode = 2'd0;
    int rel_delay = 0;
    int relcnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            status_n <= 1'b1;
            relcnt   <= 0;
        end else if (dev_mode == 2'd1) begin
            status_n <= 1'b1;
        end else if (!cfg_n) begin
            status_n <= 1'b0;
            relcnt   <= 0;
        end else if (!status_n && dev_mode == 2'd0) begin
            if (relcnt >= rel_delay) status_n <= 1'b1;
            else relcnt <= relcnt + 1;
        end
    end

    // Link monitor sampled mid-cycle.
    logic mon_clr = 1'b0;
    int low_cnt, rises, hi_run, bad_hi;
    logic [15:0] rx_bits;
    logic prev_dclk = 1'b0;
    always @(negedge clk) begin
        if (mon_clr) begin
            low_cnt = 0; rises = 0; hi_run = 0; bad_hi = 0; rx_bits = '0;
        end else begin
            if (!cfg_n) low_cnt = low_cnt + 1;
            if (dclk && !prev_dclk) begin
                if (rises < 16) rx_bits[rises] = sdata;
                rises = rises + 1;
            end
            if (dclk) hi_run = hi_run + 1;
            else if (hi_run != 0) begin
                if (hi_run != HALF) bad_hi = bad_hi + 1;
                hi_run = 0;
            end
        end
        prev_dclk = dclk;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
    endtask

    task automatic run_case(input vec_t v, input int restart_at, input string tag);
        int idx;
        bit fire;
        int exp_rises;
        dev_mode  = v.mode;
        rel_delay = int'(v.delay);
        conf_done = v.cdone;
        clear_mon();
        @(negedge clk);
        s_valid = 1'b1; s_data = v.b0; s_last = 1'b0; idx = 0; fire = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", {tag, " busy after start"}, int'(st), 1);
        chk("R8", {tag, " code cleared on start"}, int'(err), 0);
        for (int i = 0; i < 3000; i++) begin
            if (fire) begin
                idx++;
                if (idx == 1) begin s_data = v.b1; s_last = 1'b1; end
                else begin s_valid = 1'b0; s_last = 1'b0; end
            end
            start = (i == restart_at);
            fire = s_valid && s_ready;
            if (st != 2'd1) break;
            @(negedge clk);
        end
        start = 1'b0; s_valid = 1'b0; s_last = 1'b0;
        exp_rises = (v.exp_st == 2'd2) ? 16 + TAIL : ((v.exp_err == 2'd3) ? 16 : 0);
        chk("R2 R3 R6 R7", {tag, " final state"}, int'(st), int'(v.exp_st));
        chk("R2 R3 R6", {tag, " error code"}, int'(err), int'(v.exp_err));
        chk("R1", {tag, " request low cycles"}, low_cnt, PULSE);
        chk("R4 R7", {tag, " clock rising edges"}, rises, exp_rises);
        if (exp_rises >= 16)
            chk("R4", {tag, " bytes received LSB first"}, int'(rx_bits), int'({v.b1, v.b0}));
        chk("R5", {tag, " high phase width faults"}, bad_hi, 0);
        chk("R7", {tag, " clock rests low"}, int'(dclk), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "cfg_n in reset", int'(cfg_n), 1);
        chk("R10", "dclk in reset", int'(dclk), 0);
        chk("R10", "ready in reset", int'(s_ready), 0);
        chk("R10", "state in reset", int'(st), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "state idle after reset", int'(st), 0);
        chk("R10", "code after reset", int'(err), 0);
        chk("R10", "cfg_n after reset", int'(cfg_n), 1);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            run_case(VECS[k], -1, $sformatf("vec%0d", k));
            repeat (4) @(negedge clk);
        end

        // R9: start pulse in the middle of streaming
        run_case(VECS[0], 40, "restart mid-stream");
        repeat (4) @(negedge clk);

        // R10: reset during a busy run
        dev_mode = 2'd0; rel_delay = 2;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "cfg_n after mid-run reset", int'(cfg_n), 1);
        chk("R10", "dclk after mid-run reset", int'(dclk), 0);
        chk("R10", "state after mid-run reset", int'(st), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Final run after reset still works end to end
        run_case(VECS[1], -1, "post reset");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule